// File: doc/BRIEF.md
# Single-Cycle RV32I Subset Core

This block is a 32-bit processor core that completes one instruction per clock edge. During a single cycle the instruction at the current program counter is fetched, decoded, executed in the ALU, passed through the data memory if it is a load or store, and its result is committed to the register file together with the next program counter at the following rising edge. It runs fourteen RV32I instructions: ADD, SUB, AND, OR, XOR, SLT, SLL, SRL, ADDI, LW, SW, BEQ, JAL and JALR. Any other encoding is treated as a no-op.

Program and data contents are supplied as array parameters at elaboration. The instruction store is a read-only table indexed by the word address of the program counter. The data store is a word array with an asynchronous read port and a synchronous write port. Six observation outputs show the internal datapath every cycle: the program counter, the fetched word, the ALU result, the branch-taken flag, the write-back value and the data memory read value. Nothing flows into or out of the core as a stream. There is no valid/ready handshake and no back-pressure: an instruction retires on every clock edge while reset is low. Software conventionally uses x2 as a stack pointer.

Top module: `rvsc_core`

## Requirements
- R1: Outside reset, each rising edge retires exactly one instruction. After any instruction that is not a taken BEQ, a JAL or a JALR, the program counter advances by 4.
- R2: The fetched instruction is the word at index PC[IW+1:2] of the instruction table, where IW = log2(IMEM_WORDS). Bits [1:0] are ignored.
- R3: ADD, SUB, ADDI, AND, OR and XOR produce their 32-bit two's-complement or bitwise results. With opcode 0110011 and funct3 000, funct7 0100000 selects SUB and funct7 0000000 selects ADD.
- R4: SLT compares its operands as signed values and yields 1 or 0. SLL and SRL shift rs1 by rs2[4:0], and SRL fills with zeros.
- R5: Register x0 always reads as zero. A write that targets x0 is dropped.
- R6: LW and SW address the data memory at word index (rs1 + I/S immediate)[DW+1:2], where DW = log2(DMEM_WORDS). A store updates the memory at the clock edge. A load returns the stored word in the same cycle and writes it to rd.
- R7: BEQ with equal operands raises the branch-taken output and sets the next PC to PC plus the B-type immediate. With unequal operands the flag stays low and the next PC is PC+4. In both cases the ALU output shows rs1 - rs2.
- R8: JAL and JALR write PC+4 to rd. JAL jumps to PC plus the J-type immediate, and the ALU output shows that sum. JALR jumps to rs1 plus the I-type immediate with bit 0 cleared, and the ALU output shows the sum before bit 0 is cleared.
- R9: The write-back output shows the ALU result for register-register operations and ADDI, the memory word for LW, and PC+4 for jumps. It shows zero for SW, BEQ and no-ops, which write no register.
- R10: An unsupported encoding (an unknown opcode, or a known opcode with a funct3/funct7 outside the subset) advances the PC by 4, writes no register and no memory word, and keeps the branch flag low.
- R11: While the synchronous reset is high, the next edge loads PC = 0, and no register or memory write is committed.
- R12: Stack push and pop built from ADDI on x2, SW and LW round-trip a word: a return address pushed at x2-4 and popped back is usable as a JALR target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state commits on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Current program counter |
| dbg_instr | output | 32 | Instruction word fetched at dbg_pc |
| dbg_alu_result | output | 32 | ALU output of the current instruction |
| dbg_br_taken | output | 1 | High when the current BEQ is taken |
| dbg_wb_data | output | 32 | Value sent to the register file (zero when nothing is written) |
| dbg_mem_rdata | output | 32 | Data memory word at the current ALU address |

## Verification
The bench builds the core with a 32-word instruction table and a 16-word data memory. One word of the data memory is preloaded so that a load can be checked before any store has happened. These small sizes let a 28-instruction program cover all fourteen instructions, a skipped branch shadow, a call and a return through a value pushed to and popped from the stack, and an unsupported opcode. The stack sits at the top data word, so the word-index wrap is exercised as well. The bench then drives reset in the middle of the run to check that the program counter returns to zero and that execution restarts cleanly.

// File: rtl/rvsc_pkg.sv
`timescale 1ns/1ps
package rvsc_pkg;

  localparam int XLEN = 32;

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  localparam logic [31:0] NOP_WORD = 32'h0000_0013;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef enum logic [1:0] {
    AC_ADD, AC_SUB, AC_FUNCT
  } alu_class_e;

  typedef enum logic [1:0] {
    WB_NONE, WB_ALU, WB_MEM, WB_LINK
  } wb_sel_e;

  typedef enum logic [1:0] {
    IMM_I, IMM_S, IMM_B, IMM_J
  } imm_kind_e;

  typedef struct packed {
    logic       reg_we;
    logic       mem_we;
    logic       src_a_pc;
    logic       src_b_imm;
    logic       is_branch;
    logic       is_jal;
    logic       is_jalr;
    alu_class_e alu_class;
    wb_sel_e    wb_sel;
    imm_kind_e  imm_kind;
  } ctrl_t;

endpackage

// File: rtl/rvsc_decode.sv
`timescale 1ns/1ps
module rvsc_decode
  import rvsc_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl,
  output logic        legal,
  output alu_op_e     alu_op,
  output logic [31:0] imm
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];

  // ALU-control stage, part 1: decode funct fields of a register-register op
  alu_op_e r_op;
  logic    r_ok;
  always_comb begin
    r_op = ALU_ADD;
    r_ok = 1'b1;
    unique case ({f7, f3})
      {7'b0000000, 3'b000}: r_op = ALU_ADD;
      {7'b0100000, 3'b000}: r_op = ALU_SUB;
      {7'b0000000, 3'b111}: r_op = ALU_AND;
      {7'b0000000, 3'b110}: r_op = ALU_OR;
      {7'b0000000, 3'b100}: r_op = ALU_XOR;
      {7'b0000000, 3'b010}: r_op = ALU_SLT;
      {7'b0000000, 3'b001}: r_op = ALU_SLL;
      {7'b0000000, 3'b101}: r_op = ALU_SRL;
      default: r_ok = 1'b0;
    endcase
  end

  // Main decoder: opcode to control word
  ctrl_t c;
  logic  ok;
  always_comb begin
    c  = '0;
    ok = 1'b0;
    unique case (opc)
      OPC_REG: begin
        ok = r_ok;
        c.reg_we = 1'b1; c.wb_sel = WB_ALU; c.alu_class = AC_FUNCT;
      end
      OPC_IMM: begin
        ok = (f3 == 3'b000);
        c.reg_we = 1'b1; c.wb_sel = WB_ALU; c.src_b_imm = 1'b1;
        c.imm_kind = IMM_I; c.alu_class = AC_ADD;
      end
      OPC_LOAD: begin
        ok = (f3 == 3'b010);
        c.reg_we = 1'b1; c.wb_sel = WB_MEM; c.src_b_imm = 1'b1;
        c.imm_kind = IMM_I; c.alu_class = AC_ADD;
      end
      OPC_STORE: begin
        ok = (f3 == 3'b010);
        c.mem_we = 1'b1; c.src_b_imm = 1'b1;
        c.imm_kind = IMM_S; c.alu_class = AC_ADD;
      end
      OPC_BRANCH: begin
        ok = (f3 == 3'b000);
        c.is_branch = 1'b1; c.imm_kind = IMM_B; c.alu_class = AC_SUB;
      end
      OPC_JAL: begin
        ok = 1'b1;
        c.reg_we = 1'b1; c.wb_sel = WB_LINK; c.is_jal = 1'b1;
        c.src_a_pc = 1'b1; c.src_b_imm = 1'b1;
        c.imm_kind = IMM_J; c.alu_class = AC_ADD;
      end
      OPC_JALR: begin
        ok = (f3 == 3'b000);
        c.reg_we = 1'b1; c.wb_sel = WB_LINK; c.is_jalr = 1'b1;
        c.src_b_imm = 1'b1; c.imm_kind = IMM_I; c.alu_class = AC_ADD;
      end
      default: ok = 1'b0;
    endcase
    if (!ok) c = '0;
  end

  assign ctrl  = c;
  assign legal = ok;

  // ALU-control stage, part 2: choose the final operation
  always_comb begin
    unique case (c.alu_class)
      AC_SUB:   alu_op = ALU_SUB;
      AC_FUNCT: alu_op = r_op;
      default:  alu_op = ALU_ADD;
    endcase
  end

  // Immediate generator
  always_comb begin
    unique case (c.imm_kind)
      IMM_S:   imm = {{20{instr[31]}}, instr[31:25], instr[11:7]};
      IMM_B:   imm = {{19{instr[31]}}, instr[31], instr[7], instr[30:25],
                      instr[11:8], 1'b0};
      IMM_J:   imm = {{11{instr[31]}}, instr[31], instr[19:12], instr[20],
                      instr[30:21], 1'b0};
      default: imm = {{20{instr[31]}}, instr[31:20]};
    endcase
  end

  // R3: funct7 bit 5 with funct3 000 on a register op must reach SUB
  always_comb begin
    if (opc == OPC_REG && f3 == 3'b000 && f7 == 7'b0100000)
      a_r3_sub_select: assert (alu_op == ALU_SUB);
  end

  // R10: a rejected encoding commits nothing
  always_comb begin
    if (!legal)
      a_r10_reject_quiet: assert (!ctrl.reg_we && !ctrl.mem_we && !ctrl.is_branch
                                  && !ctrl.is_jal && !ctrl.is_jalr);
  end

endmodule

// File: rtl/rvsc_alu.sv
`timescale 1ns/1ps
module rvsc_alu
  import rvsc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  localparam int SHW = $clog2(W);

  logic [SHW-1:0] shamt;
  assign shamt = b[SHW-1:0];

  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL: y = a << shamt;
      ALU_SRL: y = a >> shamt;
      default: y = a + b;
    endcase
  end

  // R4: comparison result is a single bit
  always_comb begin
    if (op == ALU_SLT)
      a_r4_slt_bool: assert (y[W-1:1] == '0);
  end

  // R4: a nonzero logical right shift clears the top bit
  always_comb begin
    if (op == ALU_SRL && shamt != '0)
      a_r4_srl_zero_fill: assert (y[W-1] == 1'b0);
  end

endmodule

// File: rtl/rvsc_regfile.sv
`timescale 1ns/1ps
module rvsc_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] wa,
  input  logic [W-1:0]             wd,
  input  logic [$clog2(NREGS)-1:0] ra1,
  input  logic [$clog2(NREGS)-1:0] ra2,
  output logic [W-1:0]             rd1,
  output logic [W-1:0]             rd2
);

  localparam int AW = $clog2(NREGS);

  logic [W-1:0] view [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign view[g] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (we && wa == AW'(g)) q <= wd;
      end
      assign view[g] = q;
    end
  end

  assign rd1 = view[ra1];
  assign rd2 = view[ra2];

  // R5: register zero reads as zero on both ports
  always_comb begin
    if (ra1 == '0) a_r5_zero_port1: assert (rd1 == '0);
    if (ra2 == '0) a_r5_zero_port2: assert (rd2 == '0);
  end

endmodule

// File: rtl/rvsc_dmem.sv
`timescale 1ns/1ps
module rvsc_dmem #(
  parameter int          W     = 32,
  parameter int          WORDS = 64,
  parameter logic [31:0] INIT [WORDS] = '{default: 32'h0}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] addr,
  input  logic [W-1:0]             wdata,
  output logic [W-1:0]             rdata
);

  logic [W-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = INIT[i][W-1:0];
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  // R6: a stored word is visible at the same index on the next cycle
  a_r6_store_visible: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && !$past(rst) && $past(addr) == addr) |-> rdata == $past(wdata));

endmodule

// File: rtl/rvsc_core.sv
`timescale 1ns/1ps
module rvsc_core
  import rvsc_pkg::*;
#(
  parameter int          IMEM_WORDS = 64,
  parameter int          DMEM_WORDS = 64,
  parameter logic [31:0] IMEM_INIT [IMEM_WORDS] = '{default: 32'h0000_0013},
  parameter logic [31:0] DMEM_INIT [DMEM_WORDS] = '{default: 32'h0}
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbg_pc,
  output logic [31:0] dbg_instr,
  output logic [31:0] dbg_alu_result,
  output logic        dbg_br_taken,
  output logic [31:0] dbg_wb_data,
  output logic [31:0] dbg_mem_rdata
);

  localparam int IW    = $clog2(IMEM_WORDS);
  localparam int DW    = $clog2(DMEM_WORDS);
  localparam int NREGS = 32;

  // Program counter
  logic [31:0] pc_q, pc_next, pc_plus4, br_target;
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  // Fetch: word index taken from PC[IW+1:2]
  logic [31:0] instr;
  assign instr = IMEM_INIT[pc_q[IW+1:2]];

  // Decode
  ctrl_t       ctrl;
  logic        legal;
  alu_op_e     alu_op;
  logic [31:0] imm;
  rvsc_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl),
    .legal (legal),
    .alu_op(alu_op),
    .imm   (imm)
  );

  // Register file
  logic [31:0] rs1_v, rs2_v, wb_data;
  logic        reg_we;
  assign reg_we = ctrl.reg_we & ~rst;
  rvsc_regfile #(.W(XLEN), .NREGS(NREGS)) u_rf (
    .clk(clk),
    .we (reg_we),
    .wa (instr[11:7]),
    .wd (wb_data),
    .ra1(instr[19:15]),
    .ra2(instr[24:20]),
    .rd1(rs1_v),
    .rd2(rs2_v)
  );

  // Execute
  logic [31:0] alu_a, alu_b, alu_y;
  assign alu_a = ctrl.src_a_pc  ? pc_q : rs1_v;
  assign alu_b = ctrl.src_b_imm ? imm  : rs2_v;
  rvsc_alu #(.W(XLEN)) u_alu (
    .a (alu_a),
    .b (alu_b),
    .op(alu_op),
    .y (alu_y)
  );

  // Data memory
  logic [31:0] mem_rdata;
  logic        mem_we;
  assign mem_we = ctrl.mem_we & ~rst;
  rvsc_dmem #(.W(XLEN), .WORDS(DMEM_WORDS), .INIT(DMEM_INIT)) u_dmem (
    .clk  (clk),
    .rst  (rst),
    .we   (mem_we),
    .addr (alu_y[DW+1:2]),
    .wdata(rs2_v),
    .rdata(mem_rdata)
  );

  // Branch logic and next PC
  logic br_taken;
  assign br_taken  = ctrl.is_branch & (rs1_v == rs2_v);
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_q + imm;

  always_comb begin
    if (ctrl.is_jalr)     pc_next = {alu_y[31:1], 1'b0};
    else if (ctrl.is_jal) pc_next = alu_y;
    else if (br_taken)    pc_next = br_target;
    else                  pc_next = pc_plus4;
  end

  // Write-back selection
  always_comb begin
    unique case (ctrl.wb_sel)
      WB_ALU:  wb_data = alu_y;
      WB_MEM:  wb_data = mem_rdata;
      WB_LINK: wb_data = pc_plus4;
      default: wb_data = '0;
    endcase
  end

  assign dbg_pc         = pc_q;
  assign dbg_instr      = instr;
  assign dbg_alu_result = alu_y;
  assign dbg_br_taken   = br_taken;
  assign dbg_wb_data    = wb_data;
  assign dbg_mem_rdata  = mem_rdata;

  // R11: the first cycle after reset starts at address zero
  a_r11_reset_pc: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc_q == '0);

  // R1: straight-line instructions step the PC by one word
  a_r1_sequential_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl.is_jal) && !$past(ctrl.is_jalr) && !$past(br_taken))
    |-> pc_q == $past(pc_q) + 32'd4);

  // R7: a taken branch lands on its target
  a_r7_branch_lands: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_taken)) |-> pc_q == $past(br_target));

  // R8: an indirect jump never leaves bit 0 set
  a_r8_jalr_even: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.is_jalr)) |-> pc_q[0] == 1'b0);

  // R9: an instruction that writes no register presents zero write-back data
  a_r9_idle_wb_zero: assert property (@(posedge clk) disable iff (rst)
    !ctrl.reg_we |-> wb_data == '0);

  // R10: rejected encodings never raise the branch flag
  a_r10_no_branch_flag: assert property (@(posedge clk) disable iff (rst)
    !legal |-> !br_taken);

endmodule

// File: tb/tb_rvsc_core.sv
`timescale 1ns/1ps
module tb_rvsc_core;

  function automatic logic [31:0] fr(input logic [6:0] f7, input logic [4:0] rs2,
                                     input logic [4:0] rs1, input logic [2:0] f3,
                                     input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction

  function automatic logic [31:0] fi(input logic [31:0] v, input logic [4:0] rs1,
                                     input logic [2:0] f3, input logic [4:0] rd,
                                     input logic [6:0] op);
    return {v[11:0], rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] fs(input logic [31:0] v, input logic [4:0] rs2,
                                     input logic [4:0] rs1);
    return {v[11:5], rs2, rs1, 3'b010, v[4:0], 7'b0100011};
  endfunction

  function automatic logic [31:0] fb(input logic [31:0] v, input logic [4:0] rs2,
                                     input logic [4:0] rs1);
    return {v[12], v[10:5], rs2, rs1, 3'b000, v[4:1], v[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] fj(input logic [31:0] v, input logic [4:0] rd);
    return {v[20], v[10:1], v[11], v[19:12], rd, 7'b1101111};
  endfunction

  localparam logic [6:0] OI = 7'b0010011;
  localparam logic [6:0] OL = 7'b0000011;
  localparam logic [6:0] OJ = 7'b1100111;
  localparam logic [6:0] F0 = 7'b0000000;
  localparam logic [6:0] F1 = 7'b0100000;

  localparam logic [31:0] PROG [32] = '{
    fi(32'd5,          5'd0,  3'd0, 5'd1,  OI),   //   0 ADDI x1,x0,5
    fi(32'hFFFF_FFFD,  5'd0,  3'd0, 5'd2,  OI),   //   4 ADDI x2,x0,-3
    fr(F0, 5'd2,  5'd1, 3'd0, 5'd3),              //   8 ADD  x3,x1,x2
    fr(F1, 5'd1,  5'd2, 3'd0, 5'd4),              //  12 SUB  x4,x2,x1
    fr(F0, 5'd1,  5'd2, 3'd2, 5'd5),              //  16 SLT  x5,x2,x1
    fr(F0, 5'd2,  5'd1, 3'd2, 5'd6),              //  20 SLT  x6,x1,x2
    fr(F0, 5'd2,  5'd1, 3'd4, 5'd7),              //  24 XOR  x7,x1,x2
    fr(F0, 5'd3,  5'd1, 3'd6, 5'd8),              //  28 OR   x8,x1,x3
    fr(F0, 5'd1,  5'd2, 3'd7, 5'd9),              //  32 AND  x9,x2,x1
    fi(32'd35,         5'd0,  3'd0, 5'd10, OI),   //  36 ADDI x10,x0,35
    fr(F0, 5'd10, 5'd1, 3'd1, 5'd11),             //  40 SLL  x11,x1,x10
    fr(F0, 5'd10, 5'd2, 3'd5, 5'd12),             //  44 SRL  x12,x2,x10
    fi(32'd7,          5'd1,  3'd0, 5'd0,  OI),   //  48 ADDI x0,x1,7
    fi(32'd12,         5'd0,  3'd2, 5'd13, OL),   //  52 LW   x13,12(x0)
    fs(32'd8,  5'd1, 5'd0),                       //  56 SW   x1,8(x0)
    fi(32'd8,          5'd0,  3'd2, 5'd14, OL),   //  60 LW   x14,8(x0)
    fb(32'd8,  5'd14, 5'd1),                      //  64 BEQ  x1,x14,+8
    fi(32'd99,         5'd0,  3'd0, 5'd15, OI),   //  68 ADDI x15,x0,99 (shadow)
    fb(32'd8,  5'd2,  5'd1),                      //  72 BEQ  x1,x2,+8
    fj(32'd12, 5'd16),                            //  76 JAL  x16,+12
    fi(32'd1,          5'd0,  3'd0, 5'd17, OI),   //  80 ADDI x17,x0,1
    32'h0000_0073,                                //  84 unsupported
    fi(32'd64,         5'd0,  3'd0, 5'd2,  OI),   //  88 ADDI x2,x0,64
    fi(32'hFFFF_FFFC,  5'd2,  3'd0, 5'd2,  OI),   //  92 ADDI x2,x2,-4
    fs(32'd0,  5'd16, 5'd2),                      //  96 SW   x16,0(x2)
    fi(32'd0,          5'd2,  3'd2, 5'd18, OL),   // 100 LW   x18,0(x2)
    fi(32'd4,          5'd2,  3'd0, 5'd2,  OI),   // 104 ADDI x2,x2,4
    fi(32'd1,          5'd18, 3'd0, 5'd19, OJ),   // 108 JALR x19,x18,1
    32'h0000_0013, 32'h0000_0013, 32'h0000_0013, 32'h0000_0013
  };

  localparam logic [31:0] DINIT [16] = '{
    32'h0, 32'h0, 32'h0, 32'h1234_5678, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0
  };

  localparam int NSTEP = 28;
  localparam logic [31:0] E_PC [NSTEP] = '{
    0, 4, 8, 12, 16, 20, 24, 28, 32, 36, 40, 44, 48, 52, 56, 60, 64,
    72, 76, 88, 92, 96, 100, 104, 108, 80, 84, 88
  };
  localparam logic [31:0] E_ALU [NSTEP] = '{
    32'd5, 32'hFFFF_FFFD, 32'd2, 32'hFFFF_FFF8, 32'd1, 32'd0, 32'hFFFF_FFF8,
    32'd7, 32'd5, 32'd35, 32'd40, 32'h1FFF_FFFF, 32'd12, 32'd12, 32'd8,
    32'd8, 32'd0, 32'd8, 32'd88, 32'd64, 32'd60, 32'd60, 32'd60, 32'd64,
    32'd81, 32'd1, 32'd0, 32'd64
  };
  localparam logic [31:0] E_WB [NSTEP] = '{
    32'd5, 32'hFFFF_FFFD, 32'd2, 32'hFFFF_FFF8, 32'd1, 32'd0, 32'hFFFF_FFF8,
    32'd7, 32'd5, 32'd35, 32'd40, 32'h1FFF_FFFF, 32'd12, 32'h1234_5678, 32'd0,
    32'd5, 32'd0, 32'd0, 32'd80, 32'd64, 32'd60, 32'd0, 32'd80, 32'd64,
    32'd112, 32'd1, 32'd0, 32'd64
  };
  localparam logic [31:0] E_MR [NSTEP] = '{
    0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h1234_5678, 0, 32'd5, 0,
    0, 0, 0, 0, 0, 32'd80, 0, 0, 0, 0, 0
  };

  function automatic string req_of(input int k);
    case (k)
      4, 5, 10, 11:           return "R4";
      12:                     return "R5";
      13, 14, 15:             return "R6";
      16, 17:                 return "R7";
      18, 24, 25:             return "R8";
      19, 20, 21, 22, 23, 27: return "R12";
      26:                     return "R10";
      default:                return "R3";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc, ins, alu, wb, mr;
  logic        tk;

  always #5 clk = ~clk;

  rvsc_core #(
    .IMEM_WORDS(32), .DMEM_WORDS(16), .IMEM_INIT(PROG), .DMEM_INIT(DINIT)
  ) dut (
    .clk(clk), .rst(rst), .dbg_pc(pc), .dbg_instr(ins), .dbg_alu_result(alu),
    .dbg_br_taken(tk), .dbg_wb_data(wb), .dbg_mem_rdata(mr)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    // Reset state (R11)
    repeat (2) @(posedge clk);
    #1;
    chk("R11", "pc in reset", pc, 32'd0);
    chk("R2", "fetch at reset", ins, PROG[0]);
    @(negedge clk);
    rst = 1'b0;
    #1;

    // Vector walk: one instruction per cycle
    for (int k = 0; k < NSTEP; k++) begin
      chk("R1", $sformatf("pc step %0d", k), pc, E_PC[k]);
      chk("R2", $sformatf("fetch step %0d", k), ins, PROG[E_PC[k][6:2]]);
      if (k != 26) chk(req_of(k), $sformatf("alu step %0d", k), alu, E_ALU[k]);
      chk("R9", $sformatf("wb step %0d (%s)", k, req_of(k)), wb, E_WB[k]);
      chk("R7", $sformatf("taken step %0d", k), {31'd0, tk}, {31'd0, (k == 16)});
      if (E_MR[k] != 0) chk("R6", $sformatf("mem read step %0d", k), mr, E_MR[k]);
      @(negedge clk);
      #1;
    end

    // Reset in mid-run (R11)
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R11", "pc after mid-run reset", pc, 32'd0);
    @(posedge clk);
    #1;
    chk("R11", "pc held in reset", pc, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11", "restart wb", wb, 32'd5);
    @(negedge clk);
    #1;
    chk("R1", "restart step", pc, 32'd4);
    chk("R3", "restart second op", alu, 32'hFFFF_FFFD);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule